// File: doc/BRIEF.md
# Four-Channel Edge Capture Unit with First-Edge Polarity

This block timestamps edges on four timer input pins. Every pin first passes through a small synchroniser. Its own two-bit mode then decides whether rising edges, falling edges, both or neither cause a capture. On a capture the channel copies the free-running counter value into its latch and raises its capture flag.

Each channel also keeps a polarity bit that cannot be written. This bit tells software which direction the first captured edge took since the last read of that channel's latch. A reading routine can therefore learn whether the stored stamp began with a rising or a falling transition, even when further captures have overwritten the latch since then.

Software reaches the block through a simple register port. Reads return data combinationally. A read strobe marks a read of a latch, which matters because such a read re-arms that channel. Writes are single-cycle.

Top module: `icp_capture_unit`

## Requirements
- R1: Each pin passes through SYNC_STAGES flops (default 2) before edge detection. A pin change that is stable before a rising clock edge becomes visible on the flag, latch and polarity outputs after the third rising edge (default), and not after the second.
- R2: Channel c takes its mode from edge_sel_i[2c+1:2c]. The codes are 00 = no capture, 01 = rising edges only, 10 = falling edges only, 11 = both edges. An edge that the mode does not select changes neither the latch nor the flag.
- R3: On a capture, the channel's latch takes the value of count_i from the cycle in which the edge was detected. Reading register address c returns latch c. With no capture the latch holds its value.
- R4: A capture sets flag c, which can be read as bit c of address NUM_CH and as cap_flag_o[c]. Writing a 1 to that bit clears the flag, and writing a 0 leaves it unchanged. If a capture and a clear fall in the same cycle, the flag stays set.
- R5: The first capture on a channel after reset, or after a read of its latch, sets polarity bit c: 1 for a rising edge, 0 for a falling edge. The bit can be read as bit c of address NUM_CH+1 and as polarity_o[c].
- R6: Once the first capture has been recorded, later captures on that channel leave its polarity bit unchanged. A read strobe (rd_en_i) at latch address c re-arms tracking one cycle after the read.
- R7: Writes to the polarity address have no effect, and writes to latch addresses have no effect.
- R8: After reset, all latches, flags and polarity bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_CH | Asynchronous timer input pins |
| edge_sel_i | input | 2*NUM_CH | Per-channel edge mode, two bits each |
| count_i | input | CNT_W | Free-running timer count |
| rd_en_i | input | 1 | Read strobe; at a latch address it re-arms that channel |
| rd_addr_i | input | ADDR_W | Read register address |
| rd_data_o | output | CNT_W | Read data (combinational) |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write register address |
| wr_data_i | input | CNT_W | Write data |
| cap_latch_o | output | NUM_CH*CNT_W | All capture latches, channel 0 in the low bits |
| cap_flag_o | output | NUM_CH | Capture flags |
| polarity_o | output | NUM_CH | First-edge polarity bits |

## Verification
The case that is hardest to reach is a channel that has already recorded its first edge and then sees more captures before it is re-armed. Only the latch and the flag should move during that window, and the polarity bit should stay fixed. The stimulus puts a channel in both-edge mode and drives rise, fall and rise, reading the latch after each capture without the strobe so that the channel is not re-armed. It then issues one strobed read and follows it with a falling edge, which must turn the polarity bit from 1 to 0.

// File: rtl/icp_pkg.sv
package icp_pkg;
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_mode_e;
endpackage

// File: rtl/icp_edge_detect.sv
module icp_edge_detect #(
   parameter int NUM_CH      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pin_i,
   output logic [NUM_CH-1:0] rise_o,
   output logic [NUM_CH-1:0] fall_o
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("icp_edge_detect: SYNC_STAGES must be at least 2");
   end

   logic [NUM_CH-1:0] stage_q [SYNC_STAGES];
   logic [NUM_CH-1:0] prev_q;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stage_q[s] <= '0;
         else if (s == 0) stage_q[s] <= pin_i;
         else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= stage_q[LAST];
   end

   assign rise_o = stage_q[LAST] & ~prev_q;
   assign fall_o = ~stage_q[LAST] & prev_q;

   // R1: a detected edge must match the pin level seen SYNC_STAGES cycles earlier
   a_r1_rise_from_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_o & ~$past(pin_i, SYNC_STAGES)) == '0);
   a_r1_fall_from_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_o & $past(pin_i, SYNC_STAGES)) == '0);
endmodule

// File: rtl/icp_channel.sv
module icp_channel
   import icp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  edge_mode_e       mode_i,
   input  logic             rise_i,
   input  logic             fall_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             latch_rd_i,
   input  logic             flag_clr_i,
   output logic [CNT_W-1:0] latch_o,
   output logic             flag_o,
   output logic             pol_o
);
   logic             cap;
   logic             armed_q;
   logic             rearm_q;
   logic [CNT_W-1:0] latch_q;
   logic             flag_q;
   logic             pol_q;

   assign cap = (rise_i && (mode_i == EDGE_RISE || mode_i == EDGE_ANY)) ||
                (fall_i && (mode_i == EDGE_FALL || mode_i == EDGE_ANY));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         flag_q  <= 1'b0;
         pol_q   <= 1'b0;
         armed_q <= 1'b1;
         rearm_q <= 1'b0;
      end else begin
         rearm_q <= latch_rd_i;
         if (cap)             latch_q <= count_i;
         if (cap)             flag_q  <= 1'b1;
         else if (flag_clr_i) flag_q  <= 1'b0;
         if (cap && armed_q)  pol_q   <= rise_i;
         if (rearm_q)         armed_q <= 1'b1;
         else if (cap)        armed_q <= 1'b0;
      end
   end

   assign latch_o = latch_q;
   assign flag_o  = flag_q;
   assign pol_o   = pol_q;

   a_r3_latch_count: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> latch_o == $past(count_i));
   a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(latch_o));
   a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> flag_o);
   a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i && !cap) |=> !flag_o);
   a_r5_first_polarity: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && armed_q) |=> pol_o == $past(rise_i));
   a_r6_polarity_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap && armed_q) |=> $stable(pol_o));
endmodule

// File: rtl/icp_capture_unit.sv
module icp_capture_unit
   import icp_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W     = $clog2(NUM_CH + 2)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH-1:0]       pin_i,
   input  logic [2*NUM_CH-1:0]     edge_sel_i,
   input  logic [CNT_W-1:0]        count_i,
   input  logic                    rd_en_i,
   input  logic [ADDR_W-1:0]       rd_addr_i,
   output logic [CNT_W-1:0]        rd_data_o,
   input  logic                    wr_en_i,
   input  logic [ADDR_W-1:0]       wr_addr_i,
   input  logic [CNT_W-1:0]        wr_data_i,
   output logic [NUM_CH*CNT_W-1:0] cap_latch_o,
   output logic [NUM_CH-1:0]       cap_flag_o,
   output logic [NUM_CH-1:0]       polarity_o
);
   localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(NUM_CH);
   localparam logic [ADDR_W-1:0] POL_ADDR  = ADDR_W'(NUM_CH + 1);

   if (NUM_CH < 1 || CNT_W < NUM_CH) begin : g_bad_cfg
      $error("icp_capture_unit: need NUM_CH >= 1 and CNT_W >= NUM_CH");
   end

   logic [NUM_CH-1:0] rise, fall;
   logic [CNT_W-1:0]  latch [NUM_CH];

   icp_edge_detect #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_edges (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i),
      .rise_o (rise),
      .fall_o (fall)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic rd_hit, clr_hit;
      assign rd_hit  = rd_en_i && (rd_addr_i == ADDR_W'(c));
      assign clr_hit = wr_en_i && (wr_addr_i == FLAG_ADDR) && wr_data_i[c];

      icp_channel #(.CNT_W(CNT_W)) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .mode_i     (edge_mode_e'(edge_sel_i[2*c +: 2])),
         .rise_i     (rise[c]),
         .fall_i     (fall[c]),
         .count_i    (count_i),
         .latch_rd_i (rd_hit),
         .flag_clr_i (clr_hit),
         .latch_o    (latch[c]),
         .flag_o     (cap_flag_o[c]),
         .pol_o      (polarity_o[c])
      );
      assign cap_latch_o[c*CNT_W +: CNT_W] = latch[c];
   end

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == FLAG_ADDR)     rd_data_o[NUM_CH-1:0] = cap_flag_o;
      else if (rd_addr_i == POL_ADDR) rd_data_o[NUM_CH-1:0] = polarity_o;
      else begin
         for (int c = 0; c < NUM_CH; c++)
            if (rd_addr_i == ADDR_W'(c)) rd_data_o = latch[c];
      end
   end

   // R7: a write to the polarity address alone never moves the polarity bits
   a_r7_pol_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == POL_ADDR && rise == '0 && fall == '0) |=> $stable(polarity_o));
endmodule

// File: tb/test_icp_capture_unit.sv
module test_icp_capture_unit;
   localparam int NUM_CH = 4;
   localparam int CNT_W  = 16;
   localparam int AW     = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NUM_CH-1:0] pin = '0;
   logic [7:0]        sel = '0;
   logic [CNT_W-1:0]  cnt = '0;
   logic              rd_en = 1'b0;
   logic [AW-1:0]     rd_addr = '0;
   logic [CNT_W-1:0]  rd_data;
   logic              wr_en = 1'b0;
   logic [AW-1:0]     wr_addr = '0;
   logic [CNT_W-1:0]  wr_data = '0;
   logic [NUM_CH*CNT_W-1:0] latches;
   logic [NUM_CH-1:0] flags, pols;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   icp_capture_unit i_icp_capture_unit (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .edge_sel_i(sel), .count_i(cnt),
      .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .cap_latch_o(latches), .cap_flag_o(flags), .polarity_o(pols)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic peek(input logic [AW-1:0] a, input bit strobe, output logic [CNT_W-1:0] d);
      @(negedge clk);
      rd_addr = a;
      rd_en   = strobe;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic poke(input logic [AW-1:0] a, input logic [CNT_W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic move_pin(input int ch, input logic v);
      @(negedge clk);
      pin[ch] = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [CNT_W-1:0] d;
      chk("R8 flags", flags, 0);
      chk("R8 polarity", pols, 0);
      chk("R8 latches", latches, 0);
      peek(3'd5, 1'b0, d);
      chk("R8 polarity reg", d, 0);
   endtask

   task automatic t_rise_timing;
      logic [CNT_W-1:0] d;
      sel[1:0] = 2'b01;
      cnt = 16'h1234;
      @(negedge clk);
      pin[0] = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 not yet after two edges", flags[0], 0);
      @(negedge clk);
      chk("R1 visible after third edge", flags[0], 1);
      chk("R4 flag set", flags, 4'b0001);
      peek(3'd0, 1'b0, d);
      chk("R3 latch0", d, 16'h1234);
      chk("R5 rising gives 1", pols[0], 1);
   endtask

   task automatic t_fall_only;
      logic [CNT_W-1:0] d;
      sel[3:2] = 2'b10;
      cnt = 16'h00AB;
      move_pin(1, 1'b1);
      chk("R2 rise ignored in fall mode", flags[1], 0);
      chk("R2 latch untouched", latches[CNT_W +: CNT_W], 0);
      cnt = 16'h00CD;
      move_pin(1, 1'b0);
      chk("R2 fall captured", flags[1], 1);
      peek(3'd1, 1'b0, d);
      chk("R3 latch1", d, 16'h00CD);
      chk("R5 falling gives 0", pols[1], 0);
   endtask

   task automatic t_disabled;
      cnt = 16'h7777;
      move_pin(3, 1'b1);
      move_pin(3, 1'b0);
      chk("R2 off mode flag", flags[3], 0);
      chk("R2 off mode latch", latches[3*CNT_W +: CNT_W], 0);
   endtask

   task automatic t_flag_clear;
      logic [CNT_W-1:0] d;
      poke(3'd4, 16'h0000);
      peek(3'd4, 1'b0, d);
      chk("R4 zero write keeps flags", d, 16'h0003);
      poke(3'd4, 16'h0001);
      chk("R4 clear bit0", flags, 4'b0010);
      poke(3'd4, 16'h0002);
      chk("R4 clear bit1", flags, 4'b0000);
   endtask

   task automatic t_write_ignored;
      logic [CNT_W-1:0] d;
      poke(3'd5, 16'hFFFF);
      peek(3'd5, 1'b0, d);
      chk("R7 polarity write ignored", d, 16'h0001);
      poke(3'd0, 16'hFFFF);
      peek(3'd0, 1'b0, d);
      chk("R7 latch write ignored", d, 16'h1234);
   endtask

   task automatic t_first_edge_hold;
      logic [CNT_W-1:0] d;
      sel[5:4] = 2'b11;
      cnt = 16'h0100;
      move_pin(2, 1'b1);
      chk("R5 both mode rising", pols[2], 1);
      cnt = 16'h0200;
      move_pin(2, 1'b0);
      peek(3'd2, 1'b0, d);
      chk("R6 latch follows later fall", d, 16'h0200);
      chk("R6 polarity held after fall", pols[2], 1);
      cnt = 16'h0300;
      move_pin(2, 1'b1);
      chk("R6 polarity held after rise", pols[2], 1);
      peek(3'd2, 1'b1, d);
      chk("R6 strobed read value", d, 16'h0300);
      @(negedge clk);
      cnt = 16'h0400;
      move_pin(2, 1'b0);
      chk("R6 re-armed fall gives 0", pols[2], 0);
      chk("R6 other channel kept", pols, 4'b0001);
      chk("R3 latch2 after rearm", latches[2*CNT_W +: CNT_W], 16'h0400);
   endtask

   task automatic t_reset_again;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R8 polarity cleared", pols, 0);
      chk("R8 flags cleared", flags, 0);
      rst_n = 1'b1;
   endtask

   task automatic finish_run;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rise_timing();
      t_fall_only();
      t_disabled();
      t_flag_clear();
      t_write_ignored();
      t_first_edge_hold();
      t_reset_again();
      finish_run();
   end
endmodule